// File: doc/BRIEF.md
# Locked Split Result Register

This block holds the latest result of a converter that is wider than the read bus, up to twice the bus width. Software reads the result as two bytes. The low-byte read returns the lower bits. The high-byte read returns the remaining upper bits, zero-extended to the bus width. The read order is fixed: low byte first, then high byte. This ensures both halves come from the same conversion.

A low-byte read locks the stored value against updates from the converter. The lock stays until a high-byte read releases it. A conversion that finishes while the lock is held is dropped, not queued. Each dropped result is marked by a one-cycle pulse. A separate completion pulse still fires for every conversion, whether it was stored or dropped. The conversion controller uses that pulse to raise its interrupt flag. Read data is combinational from the strobes, so a read returns its byte in the same cycle as the strobe.

Top module: `locked_result_reg`

## Requirements
- R1: With `rd_lo` high, `rd_data` shows stored bits 7..0 in the same cycle. With only `rd_hi` high, `rd_data[1:0]` shows stored bits 9..8 and `rd_data[7:2]` reads 0. With neither strobe high, `rd_data` is 0.
- R2: A result offered on `res_valid` while the register is unlocked and `rd_lo` is low is stored, and reads return it from the next cycle on.
- R3: After a `rd_lo` strobe, the stored value does not change until a `rd_hi` strobe arrives.
- R4: A result offered while the register is locked, or in the same cycle as `rd_lo`, is discarded and leaves both bytes unchanged.
- R5: A `rd_hi` strobe releases the lock, so results offered from the next cycle on are stored. A `rd_hi` with no prior `rd_lo` returns the current high byte and leaves the register unlocked.
- R6: When `rd_hi` and `res_valid` coincide while locked, the read returns the old high byte and the new result is discarded.
- R7: `res_lost` is high for exactly one cycle after each discarded result, and is low at all other times.
- R8: `conv_done` is high for one cycle after every `res_valid`, whether the result was stored or discarded.
- R9: After reset the stored value is 0, the register is unlocked, and `res_lost` and `conv_done` are low.
- R10: When `rd_lo` and `rd_hi` are both high, `rd_data` shows the low byte and the register ends the cycle unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A new conversion result is offered this cycle |
| res_data | input | RES_W (10) | Conversion result |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | BUS_W (8) | Read data, combinational from the strobes |
| res_lost | output | 1 | One-cycle pulse after a discarded result |
| conv_done | output | 1 | One-cycle pulse after every offered result |

## Verification
The bench builds the block with its default parameters: a 10-bit result on an 8-bit bus. At that size all 1024 result codes can be swept.

Each code is stored and then read back through the full lock cycle. Each cycle is:
1. a low-byte read,
2. a result offered while locked,
3. a coincident high-byte read and new result,
4. a final read that shows the old value survived.

Directed cases then cover an unlocked high-byte read, simultaneous strobes, and a result offered in the same cycle as the low-byte read.

// File: rtl/slr_pkg.sv
package slr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/slr_lock_ctrl.sv
module slr_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic locked,
  output logic accept,
  output logic drop,
  output logic res_lost,
  output logic conv_done
);
  logic lock_nxt;

  // A result is taken only when no read pair is open or starting.
  assign drop   = res_valid & (locked | rd_lo);
  assign accept = res_valid & ~locked & ~rd_lo;

  // High read closes the pair; it wins over a simultaneous low read.
  always_comb begin
    lock_nxt = locked;
    if (rd_lo) lock_nxt = 1'b1;
    if (rd_hi) lock_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      res_lost  <= 1'b0;
      conv_done <= 1'b0;
    end else begin
      locked    <= lock_nxt;
      res_lost  <= drop;
      conv_done <= res_valid;
    end
  end

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> res_lost); // R7
  AST_LOST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_lost |-> conv_done); // R7
  AST_DONE_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> conv_done); // R8
  AST_HI_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !locked); // R5
  AST_LO_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !rd_hi |=> locked); // R3
endmodule

// File: rtl/slr_store.sv
module slr_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_data,
  output logic [RES_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wr_data;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> value == $past(wr_data)); // R2
endmodule

// File: rtl/slr_rd_mux.sv
module slr_rd_mux
  import slr_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  rd_sel_e          sel,
  input  logic [RES_W-1:0] value,
  output logic [BUS_W-1:0] rd_data
);
  localparam int HI_W = RES_W - BUS_W;

  function automatic logic [BUS_W-1:0] lo_part(input logic [RES_W-1:0] v);
    return v[BUS_W-1:0];
  endfunction

  function automatic logic [BUS_W-1:0] hi_part(input logic [RES_W-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[HI_W-1:0] = v[RES_W-1:BUS_W];
    return r;
  endfunction

  always_comb begin
    case (sel)
      SEL_LO:  rd_data = lo_part(value);
      SEL_HI:  rd_data = hi_part(value);
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    if (sel == SEL_HI)
      AST_HI_PAD_ZERO: assert (rd_data[BUS_W-1:HI_W] == '0); // R1
  end
endmodule

// File: rtl/locked_result_reg.sv
module locked_result_reg
  import slr_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [BUS_W-1:0] rd_data,
  output logic             res_lost,
  output logic             conv_done
);
  logic             locked;
  logic             accept;
  logic             drop;
  logic [RES_W-1:0] stored;
  rd_sel_e          sel;

  assign sel = rd_lo ? SEL_LO : (rd_hi ? SEL_HI : SEL_NONE);

  slr_lock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .locked    (locked),
    .accept    (accept),
    .drop      (drop),
    .res_lost  (res_lost),
    .conv_done (conv_done)
  );

  slr_store #(.RES_W(RES_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (res_data),
    .value   (stored)
  );

  slr_rd_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
    .sel     (sel),
    .value   (stored),
    .rd_data (rd_data)
  );

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(stored)); // R3
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(stored)); // R4
  AST_COINCIDE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    locked && rd_hi && res_valid |=> res_lost); // R6
  AST_BOTH_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && rd_hi |=> !locked); // R10
endmodule

// File: tb/tb_locked_result_reg.sv
module tb_locked_result_reg;
  localparam int RES_W = 10;
  localparam int BUS_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             res_valid;
  logic [RES_W-1:0] res_data;
  logic             rd_lo;
  logic             rd_hi;
  logic [BUS_W-1:0] rd_data;
  logic             res_lost;
  logic             conv_done;

  int checks = 0;
  int fails  = 0;
  int m_val  = 0;
  bit m_lock = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  locked_result_reg #(.RES_W(RES_W), .BUS_W(BUS_W)) dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
    .res_lost(res_lost), .conv_done(conv_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive, check read data, advance, check pulses, update model.
  task automatic op(input bit v, input int d, input bit lo, input bit hi,
                    input string tag);
    int  exp_rd;
    bit  exp_drop;
    res_valid = v; res_data = d[RES_W-1:0]; rd_lo = lo; rd_hi = hi;
    #1;
    if (lo)      exp_rd = m_val % 256;
    else if (hi) exp_rd = m_val / 256;
    else         exp_rd = 0;
    chk(tag, int'(rd_data), exp_rd);
    exp_drop = v && (m_lock || lo);
    if (v && !exp_drop) m_val = d;
    if (lo) m_lock = 1;
    if (hi) m_lock = 0;
    @(negedge clk);
    chk("R7", int'(res_lost), int'(exp_drop));
    chk("R8", int'(conv_done), int'(v));
    res_valid = 0; rd_lo = 0; rd_hi = 0;
  endtask

  initial begin
    rst_n = 0; res_valid = 0; res_data = '0; rd_lo = 0; rd_hi = 0;
    repeat (3) @(negedge clk);
    chk("R9", int'(res_lost), 0);
    chk("R9", int'(conv_done), 0);
    rst_n = 1;
    op(0, 0, 1, 0, "R9");
    op(0, 0, 0, 1, "R9");
    op(0, 0, 0, 0, "R1");

    for (int c = 0; c < 1024; c++) begin
      op(1, c, 0, 0, "R2");
      op(0, 0, 1, 0, "R1");
      op(1, 1023 - c, 0, 0, "R4");
      op(1, (c * 7) % 1024, 0, 1, "R6");
      op(0, 0, 1, 0, "R3");
      op(0, 0, 0, 1, "R3");
    end

    // Unlocked high read, then a result right away is taken.
    op(1, 'h2A5, 0, 0, "R2");
    op(0, 0, 0, 1, "R5");
    op(1, 'h15A, 0, 0, "R5");
    op(0, 0, 1, 0, "R5");
    op(0, 0, 0, 1, "R5");
    // Result coincident with low read is dropped.
    op(1, 'h3FF, 1, 0, "R4");
    op(0, 0, 0, 1, "R4");
    op(0, 0, 1, 0, "R4");
    op(1, 'h001, 0, 1, "R6");
    // Both strobes: low data, ends unlocked so next result lands.
    op(0, 0, 1, 1, "R10");
    op(1, 'h1C3, 0, 0, "R10");
    op(0, 0, 1, 0, "R10");
    op(0, 0, 0, 1, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule